// File: doc/BRIEF.md
# Gated Strobe Capture Register with Delayed Ready

This block holds a 16-bit word taken from a parallel input at the moment the logical AND of an enable line and a strobe line goes from low to high. Both control lines come from outside the clock domain. Each passes through a two-flop synchroniser before the rising edge is detected. The word is sampled in the same cycle that the edge is seen. The held word drives two identical output ports.

After each capture, a pair of identical ready flags rises a programmable number of clock cycles later. The flags then stay high until the next capture edge. A capture that arrives while the countdown is still running drops the flags, replaces the word and starts the countdown again. A held-high enable makes the strobe alone sufficient.

A small command port reads the word back, clears the block and programs the delay. Each valid command is acknowledged on an accept line. Separate initialise and clear lines also reset the block.

Top module: `gated_capture_reg`

## Requirements
- R1: The word on `data_i` is captured on the rising edge of (`enable_i` AND `strobe_i`), after two synchroniser stages. The held word changes on the third rising clock edge after the input change, and holds the value `data_i` had at that edge.
- R2: With `enable_i` low, strobe edges capture nothing. With `enable_i` held high, strobe edges alone capture. A rising `enable_i` while `strobe_i` is already high also captures.
- R3: `data_a_o` equals `data_b_o` and `ready_a_o` equals `ready_b_o` at all times.
- R4: Both ready flags go low on the capture edge. They go high exactly N clock edges after it, where N is the programmed delay.
- R5: Once high, the ready flags stay high until the next capture edge. A capture during a countdown drops ready, updates the word and restarts the full N-cycle countdown.
- R6: The delay N resets to 6. Command function 16 with subaddress 0 loads N from `wdata_i`, clamped into the range 3..9. Asserting `init_i` restores N to 6.
- R7: While `cmd_valid_i` is high with function 0 and subaddress 0, `rdata_o` shows the held word in the same cycle. Otherwise `rdata_o` is 0.
- R8: Function 9 with any subaddress, `init_i` or `clr_i` clears the block at the next clock edge. The word becomes 0, ready goes low and any running countdown is abandoned. A clear wins over a capture on the same edge.
- R9: `accept_o` is high, combinationally, exactly when `cmd_valid_i` is high and the command is function 0/subaddress 0, function 9 (any subaddress) or function 16/subaddress 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Parallel input word |
| enable_i | input | 1 | Capture enable, asynchronous |
| strobe_i | input | 1 | Capture strobe, asynchronous |
| data_a_o | output | 16 | Held word, port A |
| data_b_o | output | 16 | Held word, port B |
| ready_a_o | output | 1 | Delayed ready flag, port A |
| ready_b_o | output | 1 | Delayed ready flag, port B |
| cmd_valid_i | input | 1 | Command present |
| func_i | input | 5 | Command function code |
| sub_i | input | 4 | Command subaddress |
| wdata_i | input | 16 | Command write data (delay value) |
| rdata_o | output | 16 | Command read data |
| accept_o | output | 1 | Command accepted |
| init_i | input | 1 | Initialise: clear and restore default delay |
| clr_i | input | 1 | Clear |

## Verification
The bench drives inputs on falling clock edges and counts rising edges from that point. It samples the held word three edges after a capture condition is driven, and the ready flags N-1 and N edges after the capture edge, so that an early or late flag shows up. Clear and delay writes take effect one edge after the command is presented, and are sampled on the following falling edge. Read data and accept are combinational, so they are sampled a small delay after the command is driven within the same cycle.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int unsigned FUNC_W = 5;
  localparam int unsigned SUB_W  = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_READ   = 5'd0,
    FN_CLEAR  = 5'd9,
    FN_WR_DLY = 5'd16
  } gcr_func_e;

  typedef struct packed {
    logic accept;
    logic rd_sel;
    logic clr;
    logic wr_dly;
  } gcr_cmd_t;
endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/gcr_capture.sv
module gcr_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  logic              stb_s_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] data_o
);
  logic trig, trig_q;
  logic [DATA_W-1:0] data_q;

  assign trig   = en_s_i & stb_s_i;
  assign fire_o = trig & ~trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      data_q <= '0;
    end else begin
      trig_q <= trig;
      if (clr_i)       data_q <= '0;
      else if (fire_o) data_q <= data_i;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/gcr_ready_timer.sv
module gcr_ready_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             ready_o
);
  logic             busy_q, ready_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
      cnt_q   <= dly_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == DLY_W'(1)) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/gcr_ctrl.sv
module gcr_ctrl
  import gcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned DLY_DEF = 6,
  parameter int unsigned DLY_MIN = 3,
  parameter int unsigned DLY_MAX = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              init_i,
  output gcr_cmd_t          cmd_o,
  output logic [DLY_W-1:0]  dly_o
);
  logic             sub_zero;
  logic [DLY_W-1:0] dly_q, dly_clamped;

  assign sub_zero = (sub_i == '0);

  always_comb begin
    cmd_o        = '0;
    cmd_o.rd_sel = cmd_valid_i && func_i == FN_READ && sub_zero;
    cmd_o.clr    = cmd_valid_i && func_i == FN_CLEAR;
    cmd_o.wr_dly = cmd_valid_i && func_i == FN_WR_DLY && sub_zero;
    cmd_o.accept = cmd_o.rd_sel | cmd_o.clr | cmd_o.wr_dly;
  end

  always_comb begin
    if (wdata_i < DATA_W'(DLY_MIN))      dly_clamped = DLY_W'(DLY_MIN);
    else if (wdata_i > DATA_W'(DLY_MAX)) dly_clamped = DLY_W'(DLY_MAX);
    else                                 dly_clamped = wdata_i[DLY_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dly_q <= DLY_W'(DLY_DEF);
    else if (init_i)       dly_q <= DLY_W'(DLY_DEF);
    else if (cmd_o.wr_dly) dly_q <= dly_clamped;
  end

  assign dly_o = dly_q;
endmodule

// File: rtl/gated_capture_reg.sv
module gated_capture_reg
  import gcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned DLY_DEF = 6,
  parameter int unsigned DLY_MIN = 3,
  parameter int unsigned DLY_MAX = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              enable_i,
  input  logic              strobe_i,
  output logic [DATA_W-1:0] data_a_o,
  output logic [DATA_W-1:0] data_b_o,
  output logic              ready_a_o,
  output logic              ready_b_o,
  input  logic              cmd_valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              accept_o,
  input  logic              init_i,
  input  logic              clr_i
);
  logic [1:0]        sync_q;
  logic              fire, clr_req, ready;
  logic [DATA_W-1:0] data_q;
  logic [DLY_W-1:0]  dly;
  gcr_cmd_t          cmd;

  gcr_sync #(.W(2)) u_sync (
    .clk_i, .rst_ni,
    .async_i({enable_i, strobe_i}),
    .sync_o (sync_q)
  );

  gcr_ctrl #(
    .DATA_W(DATA_W), .DLY_W(DLY_W), .DLY_DEF(DLY_DEF),
    .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)
  ) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .func_i, .sub_i, .wdata_i, .init_i,
    .cmd_o(cmd), .dly_o(dly)
  );

  assign clr_req = cmd.clr | init_i | clr_i;

  gcr_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni,
    .en_s_i (sync_q[1]),
    .stb_s_i(sync_q[0]),
    .data_i,
    .clr_i  (clr_req),
    .fire_o (fire),
    .data_o (data_q)
  );

  gcr_ready_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i(fire),
    .clr_i  (clr_req),
    .dly_i  (dly),
    .ready_o(ready)
  );

  assign data_a_o  = data_q;
  assign data_b_o  = data_q;
  assign ready_a_o = ready;
  assign ready_b_o = ready;
  assign rdata_o   = cmd.rd_sel ? data_q : '0;
  assign accept_o  = cmd.accept;
endmodule

// File: rtl/gated_capture_reg_chk.sv
module gated_capture_reg_chk
  import gcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned DLY_MIN = 3,
  parameter int unsigned DLY_MAX = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fire,
  input logic              clr_req,
  input logic [DLY_W-1:0]  dly,
  input logic [DATA_W-1:0] data_a_o,
  input logic [DATA_W-1:0] data_b_o,
  input logic              ready_a_o,
  input logic              ready_b_o,
  input logic              cmd_valid_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [SUB_W-1:0]  sub_i,
  input logic              accept_o,
  input logic [DATA_W-1:0] rdata_o
);
  p_ports_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_a_o == data_b_o && ready_a_o == ready_b_o);

  p_ready_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !ready_a_o);

  p_ready_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_a_o && !fire && !clr_req |=> ready_a_o);

  p_dly_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly >= DLY_W'(DLY_MIN) && dly <= DLY_W'(DLY_MAX));

  p_idle_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> rdata_o == '0);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> data_a_o == '0 && !ready_a_o);

  p_accept_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && func_i == FN_CLEAR |-> accept_o);

  p_accept_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> !accept_o);

  p_accept_badsub_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_i == FN_READ && sub_i != '0 |-> !accept_o);
endmodule

bind gated_capture_reg gated_capture_reg_chk #(
  .DATA_W(DATA_W), .DLY_W(DLY_W), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)
) u_chk (
  .clk_i, .rst_ni, .fire, .clr_req, .dly,
  .data_a_o, .data_b_o, .ready_a_o, .ready_b_o,
  .cmd_valid_i, .func_i, .sub_i, .accept_o, .rdata_o
);

// File: tb/gated_capture_reg_test.sv
module gated_capture_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] data = '0, wdata = '0;
  logic        en = 1'b0, stb = 1'b0, cmd_valid = 1'b0, init = 1'b0, clr = 1'b0;
  logic [4:0]  func = '0;
  logic [3:0]  sub = '0;
  logic [15:0] da, db, rdata;
  logic        ra, rb, accept;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_capture_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .enable_i(en), .strobe_i(stb),
    .data_a_o(da), .data_b_o(db), .ready_a_o(ra), .ready_b_o(rb),
    .cmd_valid_i(cmd_valid), .func_i(func), .sub_i(sub), .wdata_i(wdata),
    .rdata_o(rdata), .accept_o(accept), .init_i(init), .clr_i(clr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // present a command for one edge; returns combinational results
  task automatic do_cmd(logic [4:0] f, logic [3:0] a, logic [15:0] w,
                        output logic [15:0] rd, output logic acc);
    cmd_valid = 1'b1; func = f; sub = a; wdata = w;
    #1; rd = rdata; acc = accept;
    tick(1);
    cmd_valid = 1'b0; func = '0; sub = '0; wdata = '0;
  endtask

  task automatic settle_low();
    stb = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    chk("R8 reset word", da, 0);
    chk("R4 reset ready", ra, 0);
    chk("R9 reset accept", accept, 0);
    chk("R7 reset rdata", rdata, 0);
  endtask

  task automatic t_basic_capture();
    en = 1'b1; data = 16'hA5C3; stb = 1'b1;
    tick(2);
    chk("R1 no capture before third edge", da, 0);
    tick(1);
    chk("R1 captured word", da, 16'hA5C3);
    chk("R3 port B word", db, 16'hA5C3);
    chk("R4 ready low at capture", ra, 0);
    tick(5);
    chk("R4 ready low at N-1", ra, 0);
    tick(1);
    chk("R4 ready high at N=6", ra, 1);
    chk("R3 port B ready", rb, 1);
    settle_low();
  endtask

  task automatic t_enable_gate();
    logic [15:0] rd; logic acc;
    do_cmd(5'd9, 4'd0, 16'h0, rd, acc);
    en = 1'b0; data = 16'h1234; stb = 1'b1;
    tick(5);
    chk("R2 enable low blocks capture", da, 0);
    en = 1'b1;
    tick(3);
    chk("R2 enable rise with strobe high captures", da, 16'h1234);
    settle_low();
    data = 16'h4321; stb = 1'b1;
    tick(3);
    chk("R2 strobe alone with enable high", da, 16'h4321);
  endtask

  task automatic t_hold_and_read();
    logic [15:0] rd; logic acc;
    tick(6);
    chk("R4 ready up", ra, 1);
    stb = 1'b0; data = 16'hFFFF;
    tick(20);
    chk("R5 ready held", ra, 1);
    chk("R5 word held", da, 16'h4321);
    do_cmd(5'd0, 4'd0, 16'h0, rd, acc);
    chk("R7 read word", rd, 16'h4321);
    chk("R9 read accepted", acc, 1);
    do_cmd(5'd0, 4'd2, 16'h0, rd, acc);
    chk("R7 read wrong sub gives 0", rd, 0);
    chk("R9 read wrong sub rejected", acc, 0);
    chk("R5 ready unaffected by commands", ra, 1);
  endtask

  task automatic t_restart();
    logic [15:0] rd; logic acc;
    do_cmd(5'd16, 4'd0, 16'd20, rd, acc);
    chk("R9 delay write accepted", acc, 1);
    data = 16'h0A0A; stb = 1'b1;
    tick(3);
    chk("R5 first word", da, 16'h0A0A);
    chk("R4 ready dropped on capture", ra, 0);
    stb = 1'b0;
    tick(2);
    data = 16'h0B0B; stb = 1'b1;
    tick(3);
    chk("R5 second word mid countdown", da, 16'h0B0B);
    chk("R5 ready low after restart", ra, 0);
    tick(4);
    chk("R5 old countdown did not finish", ra, 0);
    tick(4);
    chk("R6 clamped 9: low at 8", ra, 0);
    tick(1);
    chk("R6 clamped 9: high at 9", ra, 1);
    settle_low();
  endtask

  task automatic t_min_delay();
    logic [15:0] rd; logic acc;
    do_cmd(5'd16, 4'd0, 16'd1, rd, acc);
    data = 16'h7777; stb = 1'b1;
    tick(3);
    tick(2);
    chk("R6 clamped 3: low at 2", ra, 0);
    tick(1);
    chk("R6 clamped 3: high at 3", ra, 1);
    settle_low();
  endtask

  task automatic t_clear();
    logic [15:0] rd; logic acc;
    do_cmd(5'd16, 4'd0, 16'd8, rd, acc);
    data = 16'h5555; stb = 1'b1;
    tick(3);
    chk("R1 word before clear", da, 16'h5555);
    do_cmd(5'd9, 4'd7, 16'h0, rd, acc);
    chk("R9 clear any sub accepted", acc, 1);
    chk("R8 clear word", da, 0);
    chk("R8 clear ready", ra, 0);
    tick(10);
    chk("R8 countdown aborted", ra, 0);
    settle_low();
    // clr_i lands on the same edge as the capture
    data = 16'h6666; stb = 1'b1;
    tick(2);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk("R8 clear beats capture", da, 0);
    tick(10);
    chk("R8 no ready after clear/capture tie", ra, 0);
    settle_low();
  endtask

  task automatic t_init_default();
    logic [15:0] rd; logic acc;
    do_cmd(5'd16, 4'd0, 16'd3, rd, acc);
    data = 16'h9999; stb = 1'b1;
    tick(3);
    init = 1'b1;
    tick(1);
    init = 1'b0;
    chk("R8 init clears word", da, 0);
    settle_low();
    data = 16'h2468; stb = 1'b1;
    tick(3);
    tick(5);
    chk("R6 init default: low at 5", ra, 0);
    tick(1);
    chk("R6 init default: high at 6", ra, 1);
    settle_low();
  endtask

  task automatic t_accept();
    logic [15:0] rd; logic acc;
    do_cmd(5'd2, 4'd0, 16'h0, rd, acc);
    chk("R9 unknown function rejected", acc, 0);
    do_cmd(5'd16, 4'd1, 16'd4, rd, acc);
    chk("R9 write wrong sub rejected", acc, 0);
    cmd_valid = 1'b0; func = 5'd0; sub = 4'd0;
    #1;
    chk("R9 no valid no accept", accept, 0);
    chk("R7 no valid no read data", rdata, 0);
    do_cmd(5'd0, 4'd0, 16'h0, rd, acc);
    chk("R7 read after init", rd, 16'h2468);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_basic_capture();
    t_enable_gate();
    t_hold_and_read();
    t_restart();
    t_min_delay();
    t_clear();
    t_init_default();
    t_accept();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule